// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block steps a small 8-bit controller core into a reset or hardware-interrupt handler. Each idle cycle it looks at a reset request, a vector of pending interrupt sources and the global interrupt enable. If there is work to do, it picks one winner. In that same cycle it latches the word-addressed program counter and the stack pointer.

It then stores the return address on the stack through a byte-wide data-memory write port, one byte per cycle. The low byte goes first, and the stack address drops by one after every byte. In the cycle of the last byte it also presents three things: the handler address, the new stack pointer, and a one-cycle completion strobe. With that strobe it pulses either a clear for the reset request or a clear for the global enable.

The return address is `PC_BYTES` wide (1, 2 or 3 bytes). The handler address is computed as `VEC_BASE + index * VEC_SLOT`. Reset uses index 0 and source n uses index n+1.

The controller has three named states:
- `ST_IDLE` does the arbitration.
- `ST_PUSH` writes every byte except the last.
- `ST_LAST` writes the last byte and loads the vector.

Its transitions are:
- `IDLE->PUSH`: a request wins and `PC_BYTES > 1`.
- `IDLE->LAST`: a request wins and `PC_BYTES == 1`.
- `PUSH->PUSH`: more than one byte is still to be written.
- `PUSH->LAST`: exactly one byte is left.
- `LAST->IDLE`: always.
- `IDLE->IDLE`: no request.

Top module: `irq_entry_seq`

## Requirements
- R1: A reset request wins over every pending source, whatever the enable. It is serviced with `vec_idx` = 0, and `reset_clr` pulses high in the `done` cycle of that entry.
- R2: A hardware entry starts only when `gie_in` is 1 and `irq_pend` is nonzero. With no reset request and either condition false, `mem_we` stays 0.
- R3: With several pending bits set, the lowest-numbered set bit n wins, and `vec_idx` = n+1 during `done`.
- R4: Byte k of the push (k = 0 first) is written at address `sp_in - k`, where `sp_in` is the value sampled at arbitration. During `done`, `sp_wdata` = `sp_in - PC_BYTES`.
- R5: Byte k carries bits [8k+7:8k] of the sampled program counter. Exactly `PC_BYTES` bytes are written per entry.
- R6: During `done`, `pc_wdata` = `VEC_BASE + vec_idx * VEC_SLOT`, truncated to the program-counter width.
- R7: `gie_clr` pulses only in the `done` cycle of a hardware entry, and `reset_clr` only in that of a reset entry. The two never coincide.
- R8: The request is sampled at clock edge E. The first byte is written in the cycle after E. `done` is high for exactly one cycle, the cycle of byte `PC_BYTES-1`, and `mem_we` is 0 in the cycle after it.
- R9: Once arbitration has happened, changes on `reset_req`, `irq_pend`, `gie_in`, `pc_in` and `sp_in` do not affect the entry in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Reset entry request |
| irq_pend | input | NUM_SRC | Pending hardware sources, bit n = source n |
| gie_in | input | 1 | Global interrupt enable |
| pc_in | input | 8*PC_BYTES | Current word-addressed program counter (return address) |
| sp_in | input | SP_W | Current stack pointer |
| mem_we | output | 1 | Data-memory byte write strobe |
| mem_addr | output | SP_W | Write address (stack slot) |
| mem_wdata | output | 8 | Byte being pushed |
| pc_wdata | output | 8*PC_BYTES | Handler address, valid with `done` |
| sp_wdata | output | SP_W | Stack pointer after the push, valid with `done` |
| vec_idx | output | $clog2(NUM_SRC+1) | Vector index of the entry, valid with `done` |
| gie_clr | output | 1 | Clear the global enable (hardware entry) |
| reset_clr | output | 1 | Clear the reset request (reset entry) |
| done | output | 1 | Entry complete, load `pc_wdata` and `sp_wdata` |

## Verification
Some rules hold on every cycle, and the bound checker watches them continuously:
- the step-down of the write address,
- the byte count per entry and the final stack value relative to the first write,
- the single-cycle completion strobe,
- the exclusive clear pulses,
- the rule that no push begins without a qualifying request.

Other behaviour only the bench scenarios can show, because it needs values computed from the sampled inputs:
- which source wins,
- which byte lands in which slot,
- the handler address,
- the fact that inputs changed mid-entry are ignored.

The bench checks these on all three return-address widths at once.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    // Entry controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // arbitrate, capture return address and stack pointer
        ST_PUSH = 2'd1,   // write one non-final return-address byte
        ST_LAST = 2'd2    // write final byte, load vector, pulse done
    } seq_state_e;

    // Kind of entry being serviced
    typedef enum logic {
        ENT_HW  = 1'b0,
        ENT_RST = 1'b1
    } entry_kind_e;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 4
) (
    input  logic               reset_req,
    input  logic [NUM_SRC-1:0] irq_pend,
    input  logic               gie_in,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx,
    output irq_seq_pkg::entry_kind_e win_kind
);
    import irq_seq_pkg::*;

    logic             any_pend;
    logic [IDX_W-1:0] low_idx;

    // Trailing-zero search: scanning downward leaves the lowest set bit
    always_comb begin
        any_pend = 1'b0;
        low_idx  = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (irq_pend[i]) begin
                any_pend = 1'b1;
                low_idx  = IDX_W'(i + 1);
            end
        end
    end

    always_comb begin
        if (reset_req) begin
            win_valid = 1'b1;
            win_idx   = '0;
            win_kind  = ENT_RST;
        end else begin
            win_valid = gie_in && any_pend;
            win_idx   = low_idx;
            win_kind  = ENT_HW;
        end
    end

endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
    parameter int PC_W     = 16,
    parameter int IDX_W    = 4,
    parameter int VEC_BASE = 0,
    parameter int VEC_SLOT = 2
) (
    input  logic [IDX_W-1:0] idx,
    output logic [PC_W-1:0]  vec_addr
);
    localparam logic [PC_W-1:0] BASE_V = PC_W'(VEC_BASE);
    localparam logic [PC_W-1:0] SLOT_V = PC_W'(VEC_SLOT);

    always_comb begin
        vec_addr = BASE_V + PC_W'(idx) * SLOT_V;
    end

endmodule

// File: rtl/irq_byte_sel.sv
module irq_byte_sel #(
    parameter int PC_BYTES = 2,
    parameter int CNT_W    = 2
) (
    input  logic [8*PC_BYTES-1:0] pc,
    input  logic [CNT_W-1:0]      sel,
    output logic [7:0]            byte_out
);
    logic [7:0] lanes [PC_BYTES];

    for (genvar b = 0; b < PC_BYTES; b++) begin : g_lane
        assign lanes[b] = pc[8*b +: 8];
    end

    always_comb begin
        byte_out = '0;
        for (int b = 0; b < PC_BYTES; b++) begin
            if (sel == CNT_W'(b)) begin
                byte_out = lanes[b];
            end
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int NUM_SRC  = 8,
    parameter int PC_BYTES = 2,
    parameter int SP_W     = 16,
    parameter int VEC_BASE = 4,
    parameter int VEC_SLOT = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reset_req,
    input  logic [NUM_SRC-1:0]            irq_pend,
    input  logic                          gie_in,
    input  logic [8*PC_BYTES-1:0]         pc_in,
    input  logic [SP_W-1:0]               sp_in,
    output logic                          mem_we,
    output logic [SP_W-1:0]               mem_addr,
    output logic [7:0]                    mem_wdata,
    output logic [8*PC_BYTES-1:0]         pc_wdata,
    output logic [SP_W-1:0]               sp_wdata,
    output logic [$clog2(NUM_SRC+1)-1:0]  vec_idx,
    output logic                          gie_clr,
    output logic                          reset_clr,
    output logic                          done
);
    import irq_seq_pkg::*;

    localparam int PC_W  = 8 * PC_BYTES;
    localparam int IDX_W = $clog2(NUM_SRC + 1);
    localparam int CNT_W = $clog2(PC_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_PUSH_CNT = CNT_W'(PC_BYTES - 2);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PC_W-1:0]  pc_q;
    logic [SP_W-1:0]  sp_q;
    logic [IDX_W-1:0] idx_q;
    entry_kind_e      kind_q;

    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    entry_kind_e      win_kind;
    logic [PC_W-1:0]  vec_addr;
    logic [7:0]       cur_byte;

    irq_arbiter #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) arb_i (
        .reset_req (reset_req),
        .irq_pend  (irq_pend),
        .gie_in    (gie_in),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_kind  (win_kind)
    );

    irq_vec_calc #(
        .PC_W     (PC_W),
        .IDX_W    (IDX_W),
        .VEC_BASE (VEC_BASE),
        .VEC_SLOT (VEC_SLOT)
    ) vec_i (
        .idx      (idx_q),
        .vec_addr (vec_addr)
    );

    irq_byte_sel #(
        .PC_BYTES (PC_BYTES),
        .CNT_W    (CNT_W)
    ) sel_i (
        .pc       (pc_q),
        .sel      (cnt_q),
        .byte_out (cur_byte)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (win_valid) begin
                    state_d = (PC_BYTES == 1) ? ST_LAST : ST_PUSH;
                end
            end
            ST_PUSH: begin
                if (cnt_q == LAST_PUSH_CNT) begin
                    state_d = ST_LAST;
                end
            end
            ST_LAST: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured entry context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pc_q    <= '0;
            sp_q    <= '0;
            idx_q   <= '0;
            kind_q  <= ENT_HW;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (win_valid) begin
                        pc_q   <= pc_in;
                        sp_q   <= sp_in;
                        idx_q  <= win_idx;
                        kind_q <= win_kind;
                    end
                end
                ST_PUSH, ST_LAST: begin
                    sp_q  <= sp_q - SP_W'(1);
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        mem_we    = 1'b0;
        done      = 1'b0;
        gie_clr   = 1'b0;
        reset_clr = 1'b0;
        mem_addr  = sp_q;
        mem_wdata = cur_byte;
        pc_wdata  = vec_addr;
        sp_wdata  = sp_q - SP_W'(1);
        vec_idx   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                mem_wdata = '0;
            end
            ST_PUSH: begin
                mem_we = 1'b1;
            end
            ST_LAST: begin
                mem_we    = 1'b1;
                done      = 1'b1;
                gie_clr   = (kind_q == ENT_HW);
                reset_clr = (kind_q == ENT_RST);
            end
            default: begin
                mem_wdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int NUM_SRC  = 8,
    parameter int PC_BYTES = 2,
    parameter int SP_W     = 16,
    parameter int IDX_W    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reset_req,
    input logic [NUM_SRC-1:0] irq_pend,
    input logic               gie_in,
    input logic               mem_we,
    input logic [SP_W-1:0]    mem_addr,
    input logic [SP_W-1:0]    sp_wdata,
    input logic [IDX_W-1:0]   vec_idx,
    input logic               gie_clr,
    input logic               reset_clr,
    input logic               done
);
    logic [2:0]      push_n;
    logic [SP_W-1:0] start_sp_q;
    logic [SP_W-1:0] start_sp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push_n     <= '0;
            start_sp_q <= '0;
        end else if (done) begin
            push_n <= '0;
        end else if (mem_we) begin
            if (push_n == 3'd0) begin
                start_sp_q <= mem_addr;
            end
            push_n <= push_n + 3'd1;
        end
    end

    assign start_sp = (push_n == 3'd0) ? mem_addr : start_sp_q;

    AST_RESET_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reset_clr |-> (vec_idx == '0)); // R1

    AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(reset_req || (gie_in && (irq_pend != '0)))); // R2

    AST_ADDR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !done) |=> (mem_we && (mem_addr == $past(mem_addr) - SP_W'(1)))); // R4

    AST_FINAL_SP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sp_wdata == start_sp - SP_W'(PC_BYTES))); // R4

    AST_BYTE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (push_n == 3'(PC_BYTES - 1))); // R5

    AST_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(gie_clr && reset_clr)); // R7

    AST_CLR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_clr || reset_clr) |-> done); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !mem_we)); // R8

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .NUM_SRC  (NUM_SRC),
    .PC_BYTES (PC_BYTES),
    .SP_W     (SP_W),
    .IDX_W    ($clog2(NUM_SRC + 1))
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_req (reset_req),
    .irq_pend  (irq_pend),
    .gie_in    (gie_in),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .sp_wdata  (sp_wdata),
    .vec_idx   (vec_idx),
    .gie_clr   (gie_clr),
    .reset_clr (reset_clr),
    .done      (done)
);

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;

    localparam int NSRC = 8;
    localparam int VB   = 4;
    localparam int VS   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reset_req = 1'b0;
    logic [7:0]  irq_pend = '0;
    logic        gie_in = 1'b0;
    logic [23:0] pc_in = '0;
    logic [15:0] sp_in = '0;

    logic        we   [1:3];
    logic [15:0] addr [1:3];
    logic [7:0]  wd   [1:3];
    logic [15:0] spw  [1:3];
    logic [3:0]  vi   [1:3];
    logic        gc   [1:3];
    logic        rc   [1:3];
    logic        dn   [1:3];
    logic [7:0]  pcw_1;
    logic [15:0] pcw_2;
    logic [23:0] pcw_3;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_entry_seq #(.NUM_SRC(NSRC), .PC_BYTES(1), .SP_W(16), .VEC_BASE(VB), .VEC_SLOT(VS)) dut_w1 (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .irq_pend(irq_pend), .gie_in(gie_in),
        .pc_in(pc_in[7:0]), .sp_in(sp_in), .mem_we(we[1]), .mem_addr(addr[1]), .mem_wdata(wd[1]),
        .pc_wdata(pcw_1), .sp_wdata(spw[1]), .vec_idx(vi[1]), .gie_clr(gc[1]),
        .reset_clr(rc[1]), .done(dn[1]));

    irq_entry_seq #(.NUM_SRC(NSRC), .PC_BYTES(2), .SP_W(16), .VEC_BASE(VB), .VEC_SLOT(VS)) dut_i (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .irq_pend(irq_pend), .gie_in(gie_in),
        .pc_in(pc_in[15:0]), .sp_in(sp_in), .mem_we(we[2]), .mem_addr(addr[2]), .mem_wdata(wd[2]),
        .pc_wdata(pcw_2), .sp_wdata(spw[2]), .vec_idx(vi[2]), .gie_clr(gc[2]),
        .reset_clr(rc[2]), .done(dn[2]));

    irq_entry_seq #(.NUM_SRC(NSRC), .PC_BYTES(3), .SP_W(16), .VEC_BASE(VB), .VEC_SLOT(VS)) dut_w3 (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .irq_pend(irq_pend), .gie_in(gie_in),
        .pc_in(pc_in), .sp_in(sp_in), .mem_we(we[3]), .mem_addr(addr[3]), .mem_wdata(wd[3]),
        .pc_wdata(pcw_3), .sp_wdata(spw[3]), .vec_idx(vi[3]), .gie_clr(gc[3]),
        .reset_clr(rc[3]), .done(dn[3]));

    function automatic logic [31:0] get_pcw(input int w);
        case (w)
            1:       return {24'h0, pcw_1};
            2:       return {16'h0, pcw_2};
            default: return {8'h0, pcw_3};
        endcase
    endfunction

    // Expected vector index: reset first, else lowest pending bit + 1
    function automatic int exp_idx(input logic rr, input logic [7:0] pend);
        if (rr) return 0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i]) return i + 1;
        end
        return 0;
    endfunction

    function automatic logic [31:0] exp_vec(input int idx, input int w);
        logic [31:0] full;
        full = 32'(VB + idx * VS);
        return full & ((32'h1 << (8 * w)) - 32'h1);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present a request, scramble inputs after arbitration, then follow all widths
    task automatic run_entry(input logic rr, input logic [7:0] pend, input logic g,
                             input logic [23:0] pc, input logic [15:0] sp);
        logic act;
        int   eidx;
        act  = rr || (g && (pend != 8'h0));
        eidx = exp_idx(rr, pend);
        reset_req = rr;
        irq_pend  = pend;
        gie_in    = g;
        pc_in     = pc;
        sp_in     = sp;
        @(negedge clk);
        // R9: these changes must not disturb the entry in progress
        reset_req = 1'b0;
        gie_in    = 1'b0;
        irq_pend  = 8'($urandom);
        pc_in     = 24'($urandom);
        sp_in     = 16'($urandom);
        for (int k = 0; k < 4; k++) begin
            for (int w = 1; w <= 3; w++) begin
                if (act && k < w) begin
                    check("R8", "mem_we", 32'(we[w]), 32'h1);
                    check((k == 0) ? "R4" : "R9", "mem_addr", 32'(addr[w]), 32'(16'(sp - 16'(k))));
                    check("R5", "mem_wdata", 32'(wd[w]), 32'(pc[8*k +: 8]));
                    check("R8", "done", 32'(dn[w]), 32'(k == w - 1));
                    if (k == w - 1) begin
                        check("R6", "pc_wdata", get_pcw(w), exp_vec(eidx, w));
                        check("R4", "sp_wdata", 32'(spw[w]), 32'(16'(sp - 16'(w))));
                        check("R3", "vec_idx", 32'(vi[w]), 32'(eidx));
                        check("R1", "reset_clr", 32'(rc[w]), 32'(rr));
                        check("R7", "gie_clr", 32'(gc[w]), 32'(!rr));
                    end
                end else begin
                    check(act ? "R8" : "R2", "idle mem_we", 32'(we[w]), 32'h0);
                    check(act ? "R8" : "R2", "idle done", 32'(dn[w]), 32'h0);
                end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int w = 1; w <= 3; w++) begin
            check("R2", "reset mem_we", 32'(we[w]), 32'h0);
            check("R8", "reset done", 32'(dn[w]), 32'h0);
        end

        // Directed corner cases
        run_entry(1'b1, 8'hFF, 1'b1, 24'hABCDEF, 16'h08FF); // R1 reset beats all
        run_entry(1'b1, 8'h00, 1'b0, 24'h123456, 16'h0100); // R1 reset with enable off
        run_entry(1'b0, 8'hA0, 1'b1, 24'h00FF01, 16'h0002); // R3 lowest of several
        run_entry(1'b0, 8'h80, 1'b1, 24'hFEDCBA, 16'h0001); // R3 highest source, SP wraps (R4)
        run_entry(1'b0, 8'h01, 1'b1, 24'h0A0B0C, 16'hFFFF); // R3 source 0
        run_entry(1'b0, 8'hFF, 1'b0, 24'h111111, 16'h0500); // R2 enable off
        run_entry(1'b0, 8'h00, 1'b1, 24'h222222, 16'h0500); // R2 nothing pending

        // Constrained random mix
        for (int n = 0; n < 80; n++) begin
            logic        rr;
            logic [7:0]  pend;
            logic        g;
            rr   = ($urandom % 8) == 0;
            pend = (($urandom % 5) == 0) ? 8'h00 : 8'($urandom & $urandom);
            g    = ($urandom % 4) != 0;
            run_entry(rr, pend, g, 24'($urandom), 16'($urandom));
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule